// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the software-facing register window of an event-timer unit. It owns a free-running 64-bit main counter that advances on a tick strobe. It also holds the global configuration, the identity and capability words, the tick-period constant and a per-channel interrupt status register. A simple register bus reaches all of these through a 1 KB window, using either a 4-byte or an 8-byte access.

Offsets 0x100 up to 0x3FF form the channel area, with one 32-byte slot per channel. Accesses there are not served locally. They are forwarded to an external bank of comparator channels as a channel index, an offset within the slot and two 32-bit word lanes. An 8-byte access to any register other than the main counter is handled as two word accesses: the low word at the offset and the high word at offset+4. An 8-byte read of the main counter takes both halves from one sample, so a carry out of the low word can never be torn.

Read data is registered. It appears on the read-data port one clock after the cycle in which the read strobe is sampled, and it holds until the next read.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset the configuration bits, the main counter, the interrupt status bits and the read data are all zero.
- R2: A read is registered: the value of the addressed word appears on rdata_o after the clock edge that samples rd_en_i, and it holds until the next read. The word at offset 0x000 reads {VENDOR_ID[31:16], 1 at bit 15 (legacy routing capable), 0 at bit 14, 1 at bit 13 (64-bit counter), N_CH-1 in bits 12:8, REV_ID[7:0]}. The word at 0x004 reads the tick period TICK_FS, which is 69841279 fs by default.
- R3: The configuration word at 0x010 keeps only bit 0 (global enable, driven on glb_en_o) and bit 1 (legacy routing, driven on legacy_en_o). All other bits read as zero, and the word changes only when it is written.
- R4: While the global enable is set, the main counter rises by exactly one on every cycle with tick_en_i high. While the enable is clear, the counter holds its value.
- R5: The counter's low word (0x0F0) and high word (0x0F4) can be written only while the global enable is clear. A write made while the enable is set has no effect.
- R6: An 8-byte read at 0x0F0 returns both counter halves from the same clock. Any other 8-byte access acts as a word access at the offset (bits 31:0) followed by a word access at offset+4 (bits 63:32).
- R7: Bit i of the status word at 0x020 is set by sts_set_i[i] and is cleared by writing a 1 to it. If a set and a clear reach the same bit in the same cycle, the set wins.
- R8: An access at an offset from 0x100 to 0x3FF drives chan_idx_o = (offset-0x100)/32 and chan_off_o = (offset-0x100) mod 32. It raises lane bit 0 for the word at chan_off_o and, for an 8-byte access, lane bit 1 for the word at chan_off_o+4. Reads return chan_rdata_i, with lane 0 in bits 31:0.
- R9: A channel index of N_CH or above raises no lane strobe and reads as zero.
- R10: An 8-byte access whose offset is not a multiple of 8, or a 4-byte access whose offset is not a multiple of 4, is ignored: it writes nothing, raises no strobe and reads zero.
- R11: Offsets that map to no register read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Counter advance strobe |
| addr_i | input | 10 | Byte offset in the register window |
| wdata_i | input | 64 | Write data; bits 31:0 for 4-byte accesses |
| size8_i | input | 1 | 1 for an 8-byte access, 0 for 4 bytes |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 64 | Registered read data |
| sts_set_i | input | N_CH | Per-channel interrupt status set pulses |
| glb_en_o | output | 1 | Global enable |
| legacy_en_o | output | 1 | Legacy routing enable |
| count_o | output | 64 | Main counter value |
| chan_idx_o | output | 5 | Channel index of the current access |
| chan_off_o | output | 5 | Byte offset inside the channel slot |
| chan_rd_o | output | 2 | Channel read strobes per word lane |
| chan_wr_o | output | 2 | Channel write strobes per word lane |
| chan_wdata_o | output | 64 | Write data forwarded to the channels |
| chan_rdata_i | input | 64 | Channel read data, lane 0 in bits 31:0 |

## Verification
The bench builds the block with N_CH = 3. With that value, channel indices 3 to 23 all lie inside the channel area but are not implemented, which exercises the out-of-range path well inside the window. Slot 23 at 0x3E0 also sits at the top edge of the decode. The counter is preloaded to just below the 32-bit boundary so that an 8-byte read lands right on the low-word carry. The default 64-bit counter width and the fixed period constant are the values checked against the capability and period words.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned SLOT_W = 5;

  localparam logic [ADDR_W-1:0] A_CAP    = 10'h000;
  localparam logic [ADDR_W-1:0] A_PER    = 10'h004;
  localparam logic [ADDR_W-1:0] A_CFG    = 10'h010;
  localparam logic [ADDR_W-1:0] A_STS    = 10'h020;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 10'h0F4;
  localparam logic [ADDR_W-1:0] A_CH_BASE = 10'h100;

  typedef struct packed {
    logic              ok;      // alignment legal for access size
    logic              chan;    // inside channel area
    logic              in_rng;  // channel index implemented
    logic [SLOT_W-1:0] idx;
    logic [SLOT_W-1:0] off;
  } dec_t;
endpackage

// File: rtl/evt_addr_dec.sv
`timescale 1ns/1ps
module evt_addr_dec
  import evt_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              size8_i,
  output dec_t              dec_o
);
  logic [ADDR_W-1:0] rel;

  assign rel = addr_i - A_CH_BASE;

  always_comb begin
    dec_o.ok     = size8_i ? (addr_i[2:0] == 3'd0) : (addr_i[1:0] == 2'd0);
    dec_o.chan   = (addr_i[ADDR_W-1:8] != '0);
    dec_o.idx    = rel[ADDR_W-1:SLOT_W];
    dec_o.off    = rel[SLOT_W-1:0];
    dec_o.in_rng = dec_o.chan && (int'(rel[ADDR_W-1:SLOT_W]) < N_CH);
  end
endmodule

// File: rtl/evt_main_cnt.sv
`timescale 1ns/1ps
module evt_main_cnt #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [1:0]       we_i,
  input  logic [CNT_W-1:0] wd_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int HALF = CNT_W / 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (!en_i && (we_i != 2'b00)) begin
      // software load allowed only while stopped
      if (we_i[0]) cnt_o[HALF-1:0]     <= wd_i[HALF-1:0];
      if (we_i[1]) cnt_o[CNT_W-1:HALF] <= wd_i[CNT_W-1:HALF];
    end else if (en_i && tick_i) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/evt_timer_regs.sv
`timescale 1ns/1ps
module evt_timer_regs
  import evt_pkg::*;
#(
  parameter int          N_CH      = 3,
  parameter logic [31:0] TICK_FS   = 32'd69841279,
  parameter logic [15:0] VENDOR_ID = 16'h1AB5,
  parameter logic [7:0]  REV_ID    = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic [9:0]        addr_i,
  input  logic [63:0]       wdata_i,
  input  logic              size8_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [63:0]       rdata_o,
  input  logic [N_CH-1:0]   sts_set_i,
  output logic              glb_en_o,
  output logic              legacy_en_o,
  output logic [63:0]       count_o,
  output logic [4:0]        chan_idx_o,
  output logic [4:0]        chan_off_o,
  output logic [1:0]        chan_rd_o,
  output logic [1:0]        chan_wr_o,
  output logic [63:0]       chan_wdata_o,
  input  logic [63:0]       chan_rdata_i
);
  localparam int N_LANE = 2;
  localparam logic [31:0] CAP_WORD =
    {VENDOR_ID, 1'b1, 1'b0, 1'b1, 5'(N_CH - 1), REV_ID};

  dec_t dec;
  logic [1:0]      cfg_q;
  logic [N_CH-1:0] sts_q;
  logic [63:0]     cnt;

  logic [N_LANE-1:0] lane_act, hit_cfg, hit_sts, hit_lo, hit_hi;
  logic [9:0]        lane_a  [N_LANE];
  logic [31:0]       lane_wd [N_LANE];
  logic [31:0]       lane_rd [N_LANE];
  logic              wr_glb;

  evt_addr_dec #(.N_CH(N_CH)) u_dec (
    .addr_i (addr_i),
    .size8_i(size8_i),
    .dec_o  (dec)
  );

  assign wr_glb = wr_en_i && dec.ok && !dec.chan;

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    logic [31:0] rd_w;
    assign lane_act[l] = dec.ok && ((l == 0) || size8_i);
    assign lane_a[l]   = addr_i + 10'(4 * l);
    assign lane_wd[l]  = wdata_i[32*l +: 32];
    assign hit_cfg[l]  = wr_glb && lane_act[l] && (lane_a[l] == A_CFG);
    assign hit_sts[l]  = wr_glb && lane_act[l] && (lane_a[l] == A_STS);
    assign hit_lo[l]   = wr_glb && lane_act[l] && (lane_a[l] == A_CNT_LO);
    assign hit_hi[l]   = wr_glb && lane_act[l] && (lane_a[l] == A_CNT_HI);
    always_comb begin
      case (lane_a[l])
        A_CAP:    rd_w = CAP_WORD;
        A_PER:    rd_w = TICK_FS;
        A_CFG:    rd_w = {30'd0, cfg_q};
        A_STS:    rd_w = 32'(sts_q);
        A_CNT_LO: rd_w = cnt[31:0];
        A_CNT_HI: rd_w = cnt[63:32];
        default:  rd_w = 32'd0;
      endcase
    end
    assign lane_rd[l] = rd_w;
  end

  // configuration
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cfg_q <= 2'b00;
    else if (|hit_cfg)     cfg_q <= hit_cfg[1] ? lane_wd[1][1:0] : lane_wd[0][1:0];
  end

  // interrupt status: set wins over write-one-to-clear
  logic [N_CH-1:0] sts_clr;
  assign sts_clr = (hit_sts[0] ? lane_wd[0][N_CH-1:0] : '0)
                 | (hit_sts[1] ? lane_wd[1][N_CH-1:0] : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~sts_clr) | sts_set_i;
  end

  // main counter
  logic [1:0]  cnt_we;
  logic [63:0] cnt_wd;
  assign cnt_we = {|hit_hi, |hit_lo};
  assign cnt_wd = {hit_hi[1] ? lane_wd[1] : lane_wd[0],
                   hit_lo[1] ? lane_wd[1] : lane_wd[0]};

  evt_main_cnt #(.CNT_W(64)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cfg_q[0]),
    .tick_i(tick_en_i),
    .we_i  (cnt_we),
    .wd_i  (cnt_wd),
    .cnt_o (cnt)
  );

  // read path; one register stage samples both counter halves together
  logic [63:0] rd_next;
  always_comb begin
    if (!dec.ok)       rd_next = '0;
    else if (dec.chan) rd_next = dec.in_rng ?
                         {size8_i ? chan_rdata_i[63:32] : 32'd0, chan_rdata_i[31:0]} : '0;
    else               rd_next = {lane_act[1] ? lane_rd[1] : 32'd0, lane_rd[0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_next;
  end

  // channel bank routing
  logic chan_go;
  assign chan_go      = dec.ok && dec.in_rng;
  assign chan_idx_o   = dec.idx;
  assign chan_off_o   = dec.off;
  assign chan_rd_o    = (rd_en_i && chan_go) ? {size8_i, 1'b1} : 2'b00;
  assign chan_wr_o    = (wr_en_i && chan_go) ? {size8_i, 1'b1} : 2'b00;
  assign chan_wdata_o = wdata_i;

  assign glb_en_o    = cfg_q[0];
  assign legacy_en_o = cfg_q[1];
  assign count_o     = cnt;
endmodule

// File: rtl/evt_timer_regs_chk.sv
`timescale 1ns/1ps
module evt_timer_regs_chk #(
  parameter int N_CH = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_en_i,
  input logic [9:0]  addr_i,
  input logic        size8_i,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic [63:0] rdata_o,
  input logic        glb_en_o,
  input logic        legacy_en_o,
  input logic [63:0] count_o,
  input logic [4:0]  chan_idx_o,
  input logic [1:0]  chan_rd_o,
  input logic [1:0]  chan_wr_o
);
  assert_cnt_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_en_o && tick_en_i) |=> count_o == $past(count_o) + 64'd1);

  assert_cnt_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_en_o && !wr_en_i) |=> count_o == $past(count_o));

  assert_cnt_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_en_o && !tick_en_i) |=> $stable(count_o));

  assert_cfg_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable({glb_en_o, legacy_en_o}));

  assert_atomic_cnt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && size8_i && addr_i == 10'h0F0) |=> rdata_o == $past(count_o));

  assert_lane_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_rd_o[1] || chan_wr_o[1]) |-> (size8_i && (chan_rd_o[0] || chan_wr_o[0])));

  assert_idx_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(chan_idx_o) >= N_CH) |-> (chan_rd_o == 2'b00 && chan_wr_o == 2'b00));

  assert_misalign_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && size8_i && addr_i[2:0] != 3'd0) |=> rdata_o == 64'd0);
endmodule

bind evt_timer_regs evt_timer_regs_chk #(.N_CH(N_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_en_i  (tick_en_i),
  .addr_i     (addr_i),
  .size8_i    (size8_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .rdata_o    (rdata_o),
  .glb_en_o   (glb_en_o),
  .legacy_en_o(legacy_en_o),
  .count_o    (count_o),
  .chan_idx_o (chan_idx_o),
  .chan_rd_o  (chan_rd_o),
  .chan_wr_o  (chan_wr_o)
);

// File: tb/evt_timer_regs_bench.sv
`timescale 1ns/1ps
module evt_timer_regs_bench;
  localparam int          N_CH = 3;
  localparam logic [31:0] PER  = 32'd69841279;
  localparam logic [31:0] CAP  = {16'h1AB5, 1'b1, 1'b0, 1'b1, 5'd2, 8'h01};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, s8 = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [9:0]  addr = '0;
  logic [63:0] wd = '0;
  logic [N_CH-1:0] set = '0;
  logic [63:0] rdata, count, chan_wdata, chan_rdata;
  logic glb_en, leg_en;
  logic [4:0] chan_idx, chan_off;
  logic [1:0] chan_rd, chan_wr;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // stand-in channel bank: data encodes index and offset of each lane
  assign chan_rdata = {16'hD000, 3'b0, chan_idx, 3'b0, chan_off + 5'd4,
                       16'hC000, 3'b0, chan_idx, 3'b0, chan_off};

  evt_timer_regs #(.N_CH(N_CH)) u_evt_timer_regs (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick), .addr_i(addr), .wdata_i(wd),
    .size8_i(s8), .wr_en_i(wr), .rd_en_i(rd), .rdata_o(rdata), .sts_set_i(set),
    .glb_en_o(glb_en), .legacy_en_o(leg_en), .count_o(count),
    .chan_idx_o(chan_idx), .chan_off_o(chan_off), .chan_rd_o(chan_rd),
    .chan_wr_o(chan_wr), .chan_wdata_o(chan_wdata), .chan_rdata_i(chan_rdata)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic [1:0]      m_cfg;
  logic [N_CH-1:0] m_sts;
  logic [63:0]     m_cnt, m_rd;

  function automatic logic [31:0] ch_lo(int idx, int off);
    return {16'hC000, 3'b0, 5'(idx), 3'b0, 5'(off)};
  endfunction
  function automatic logic [31:0] ch_hi(int idx, int off);
    return {16'hD000, 3'b0, 5'(idx), 3'b0, 5'(off + 4)};
  endfunction
  function automatic logic [31:0] mword(int a);
    case (a)
      'h000: return CAP;
      'h004: return PER;
      'h010: return {30'd0, m_cfg};
      'h020: return 32'(m_sts);
      'h0F0: return m_cnt[31:0];
      'h0F4: return m_cnt[63:32];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = '0; m_sts = '0; m_cnt = '0; m_rd = '0;
    end else begin
      int a, idx, off;
      bit ok, ch;
      logic [1:0] n_cfg;
      logic [N_CH-1:0] n_sts;
      logic [63:0] n_cnt;
      a = int'(addr);
      ok = s8 ? (a % 8 == 0) : (a % 4 == 0);
      ch = (a >= 256);
      idx = (a - 256) / 32;
      off = (a - 256) % 32;
      n_cfg = m_cfg; n_sts = m_sts; n_cnt = m_cnt;
      if (rd) begin
        if (!ok)     m_rd = '0;
        else if (ch) m_rd = (idx < N_CH) ? {s8 ? ch_hi(idx, off) : 32'd0, ch_lo(idx, off)} : '0;
        else         m_rd = {s8 ? mword(a + 4) : 32'd0, mword(a)};
      end
      if (wr && ok && !ch) begin
        for (int k = 0; k < (s8 ? 2 : 1); k++) begin
          int aa;
          logic [31:0] d;
          aa = a + 4 * k;
          d = wd[32*k +: 32];
          case (aa)
            'h010: n_cfg = d[1:0];
            'h020: n_sts = n_sts & ~d[N_CH-1:0];
            'h0F0: if (!m_cfg[0]) n_cnt[31:0] = d;
            'h0F4: if (!m_cfg[0]) n_cnt[63:32] = d;
            default: ;
          endcase
        end
      end
      if (m_cfg[0] && tick) n_cnt = n_cnt + 64'd1;
      n_sts = n_sts | set;
      m_cfg = n_cfg; m_sts = n_sts; m_cnt = n_cnt;
    end
  end

  task automatic cmp_regs();
    check64("R4 R5 counter", count, m_cnt);
    check64("R3 config outputs", {62'd0, leg_en, glb_en}, {62'd0, m_cfg});
    check64("R2 R6 R8 R11 read data", rdata, m_rd);
  endtask

  task automatic cmp_strobes();
    int a, idx;
    bit ok, ch;
    logic [1:0] e_rd, e_wr;
    a = int'(addr);
    ok = s8 ? (a % 8 == 0) : (a % 4 == 0);
    ch = (a >= 256);
    idx = (a - 256) / 32;
    e_rd = (rd && ok && ch && idx < N_CH) ? {s8, 1'b1} : 2'b00;
    e_wr = (wr && ok && ch && idx < N_CH) ? {s8, 1'b1} : 2'b00;
    check64("R8 R9 R10 lane strobes", {60'd0, chan_rd, chan_wr}, {60'd0, e_rd, e_wr});
    if (ch) check64("R8 index/offset", {54'd0, chan_idx, chan_off},
                    {54'd0, 5'(idx), 5'((a - 256) % 32)});
  endtask

  // one bus cycle; compares the previous edge's results, then drives
  task automatic step(input logic w, input logic r, input logic sz, input logic [9:0] a,
                      input logic [63:0] d, input logic t, input logic [N_CH-1:0] st);
    @(negedge clk);
    cmp_regs();
    wr = w; rd = r; s8 = sz; addr = a; wd = d; tick = t; set = st;
    #1;
    cmp_strobes();
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n, input logic t);
    for (int i = 0; i < n; i++) step(0, 0, 0, 10'h000, '0, t, '0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check64("R1 reset counter", count, 64'd0);
    check64("R1 reset cfg", {62'd0, leg_en, glb_en}, 64'd0);
    check64("R1 reset rdata", rdata, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2, 1);

    // R2 identity and period words
    step(0, 1, 0, 10'h000, '0, 1, '0);
    after_edge();
    check64("R2 capability word", rdata, {32'd0, CAP});
    step(0, 1, 0, 10'h004, '0, 0, '0);
    after_edge();
    check64("R2 period word", rdata, {32'd0, PER});
    idle(2, 0);
    check64("R2 read data holds", rdata, {32'd0, PER});
    // R6 split 8-byte read of identity
    step(0, 1, 1, 10'h000, '0, 0, '0);
    after_edge();
    check64("R6 split 8-byte read", rdata, {PER, CAP});

    // R5 counter load while stopped, then hold while ticking (R4)
    step(1, 0, 1, 10'h0F0, 64'h0000_0001_FFFF_FFF0, 0, '0);
    idle(5, 1);
    step(0, 1, 1, 10'h0F0, '0, 1, '0);
    after_edge();
    check64("R4 counter holds while disabled", rdata, 64'h0000_0001_FFFF_FFF0);
    step(1, 0, 0, 10'h0F4, 64'h0000_0000_0000_0001, 0, '0);

    // R3 enable with extra bits set; only two bits kept
    step(1, 0, 0, 10'h010, 64'hFFFF_FFFF_FFFF_FFFD, 0, '0);
    for (int i = 0; i < 16; i++) step(0, 0, 0, 10'h000, '0, 1, '0);
    // R6 coherent read exactly on the low-word carry
    step(0, 1, 1, 10'h0F0, '0, 1, '0);
    after_edge();
    check64("R6 coherent counter read", rdata, 64'h0000_0002_0000_0000);
    step(0, 1, 0, 10'h010, '0, 0, '0);
    after_edge();
    check64("R3 config readback", rdata, 64'd1);
    // R5 writes ignored while running
    step(1, 0, 1, 10'h0F0, 64'h1234_5678_9ABC_DEF0, 0, '0);
    step(1, 0, 0, 10'h0F4, 64'h5555, 1, '0);
    for (int i = 0; i < 7; i++) step(0, 0, 0, 10'h000, '0, i[0], '0);
    step(0, 1, 1, 10'h0F0, '0, 0, '0);
    after_edge();
    check64("R5 write ignored while enabled", rdata, 64'h0000_0002_0000_0005);

    // R7 status set, clear, and set-wins collision
    step(0, 0, 0, 10'h000, '0, 0, 3'b111);
    step(1, 0, 0, 10'h020, 64'h2, 0, '0);
    step(0, 1, 0, 10'h020, '0, 0, '0);
    after_edge();
    check64("R7 write-one-to-clear", rdata, 64'h5);
    step(1, 0, 0, 10'h020, 64'h5, 0, 3'b001);
    step(0, 1, 1, 10'h020, '0, 0, '0);
    after_edge();
    check64("R7 set wins over clear", rdata, 64'h1);

    // R8 channel routing
    step(0, 1, 0, 10'h100, '0, 1, '0);
    step(0, 1, 1, 10'h128, '0, 1, '0);
    after_edge();
    check64("R8 channel 1 8-byte read", rdata, {16'hD000, 8'd1, 8'h0C, 16'hC000, 8'd1, 8'h08});
    step(1, 0, 1, 10'h150, 64'hAAAA_BBBB_CCCC_DDDD, 0, '0);
    step(1, 0, 0, 10'h15C, 64'h1, 0, '0);
    // R9 unimplemented channels
    step(0, 1, 1, 10'h160, '0, 0, '0);
    after_edge();
    check64("R9 channel 3 reads zero", rdata, 64'd0);
    step(1, 0, 1, 10'h3E0, '1, 0, '0);
    step(0, 1, 0, 10'h3FC, '0, 0, '0);

    // R10 misaligned accesses
    step(0, 1, 1, 10'h000, '0, 0, '0);
    step(0, 1, 1, 10'h104, '0, 0, '0);
    after_edge();
    check64("R10 misaligned 8-byte read", rdata, 64'd0);
    step(1, 0, 1, 10'h104, '1, 0, '0);
    step(1, 0, 0, 10'h012, 64'h0, 0, '0);
    step(0, 1, 0, 10'h010, '0, 0, '0);
    after_edge();
    check64("R10 misaligned write ignored", rdata, 64'd1);

    // R11 unmapped offsets
    step(1, 0, 0, 10'h030, 64'hFFFF_FFFF, 0, '0);
    step(1, 0, 1, 10'h018, '1, 0, '0);
    step(0, 1, 1, 10'h030, '0, 0, '0);
    after_edge();
    check64("R11 unmapped read zero", rdata, 64'd0);
    step(0, 1, 1, 10'h0F8, '0, 0, '0);
    step(0, 1, 1, 10'h010, '0, 0, '0);
    after_edge();
    check64("R11 write to unmapped left cfg", rdata, 64'd1);

    // R3 legacy bit and disable, R4 hold afterwards
    step(1, 0, 0, 10'h010, 64'h2, 1, '0);
    idle(4, 1);
    step(0, 1, 1, 10'h010, '0, 1, '0);
    after_edge();
    check64("R3 legacy only", rdata, 64'h2);
    idle(2, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule